// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Register

This block collects the interrupt-worthy events of an Ethernet MAC into one 32-bit sticky register that software clears by writing ones. A second register of the same layout selects which latched events drive the single interrupt output. Simple conditions reach the block as one-cycle strobes from the transmit, receive, FIFO and management logic. Three conditions are detected inside the block: a missing collision pulse after a transmission (heartbeat check), frames that grow longer than a programmed maximum in either direction, and completion of a graceful transmit stop.

A graceful stop can be requested in three ways: by a rising edge on the software stop level, by a rising edge on the software pause-request level, or by a strobe that reports a valid received pause frame. The stop completes once the frame on the wire has ended. If no frame is in progress, it completes at once. Frame lengths are counted from byte-valid strobes, and end-of-frame marks the last byte. The block only flags an over-long frame and never cuts it short.

Top module: `mac_irq_event`

## Requirements
- R1: After reset, the event register and the mask register both read 0, and irq_o is low.
- R2: The implemented event bits are: heartbeat error 31, receive babble 30, transmit babble 29, graceful stop complete 28, frame transmitted 27, management done 23, late collision 21, retry limit 20, transmit FIFO underrun 19, transmit FIFO error 18, receive FIFO error 17. All other bits of both registers read 0 and ignore writes. reg_sel_i=0 selects the event register and reg_sel_i=1 selects the mask register.
- R3: A write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. An event bit is never cleared any other way.
- R4: If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: A write to the mask register replaces its implemented bits, and it reads back. irq_o is high exactly when some event bit and the mask bit at the same position are both 1. Masked events still latch.
- R6: If hb_en_i is high when tx_eof_i is high, a window of hb_window_i cycles opens on the next cycle (a value of 0 acts as 1). If col_i stays low on every cycle of the window, bit 31 reads 1 on the cycle after the window's last cycle. A new end-of-frame restarts the window.
- R7: Each direction counts bytes per frame. At the first byte whose count exceeds max_len_i, bit 30 (receive) or bit 29 (transmit) is set, and it is not set again before that frame's end-of-frame. The count restarts after the end-of-frame byte.
- R8: A graceful stop request (rising gts_req_i, rising tfc_req_i, or an rx_pause_i strobe) made during a transmit frame sets bit 28 two cycles after that frame's tx_eof_i cycle, and not before.
- R9: A graceful stop request made with no transmit frame in progress sets bit 28 two cycles after the request cycle.
- R10: Each single-cycle strobe sets its own bit one cycle later: tx_done_i to 27, mii_done_i to 23, late_col_i to 21, retry_lim_i to 20, tx_under_i to 19, tx_ferr_i to 18, rx_ferr_i to 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register select: 0 event, 1 mask |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| hb_en_i | input | 1 | Heartbeat check enable |
| hb_window_i | input | HB_W | Heartbeat window length in cycles |
| max_len_i | input | LEN_W | Maximum frame length in bytes |
| gts_req_i | input | 1 | Software stop request level |
| tfc_req_i | input | 1 | Software pause-frame request level |
| rx_pause_i | input | 1 | Valid pause frame received strobe |
| tx_byte_i | input | 1 | Transmit byte valid |
| tx_eof_i | input | 1 | Transmit last byte |
| rx_byte_i | input | 1 | Receive byte valid |
| rx_eof_i | input | 1 | Receive last byte |
| col_i | input | 1 | Collision input |
| tx_done_i | input | 1 | Frame transmitted strobe |
| mii_done_i | input | 1 | Management transfer done strobe |
| late_col_i | input | 1 | Late collision strobe |
| retry_lim_i | input | 1 | Retry limit strobe |
| tx_under_i | input | 1 | Transmit FIFO underrun strobe |
| tx_ferr_i | input | 1 | Transmit FIFO error strobe |
| rx_ferr_i | input | 1 | Receive FIFO error strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that reserved bits stay zero in both registers, that a set wins over a same-cycle clear, that a clearing write removes exactly the written bits, and that bits are not lost without a write. They also check that a collision closes the heartbeat window, that a babble detector fires at most once per frame, and that a completed stop releases its pending state. Only the bench scenarios show the exact cycle at which a heartbeat error, a babble bit or a stop completion appears. The same holds for the three stop triggers, idle versus in-frame completion, and the mask-gated interrupt under mixed traffic. A behavioural reference model checks all of these on every clock.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned BIT_HB     = 31;
  localparam int unsigned BIT_RXBAB  = 30;
  localparam int unsigned BIT_TXBAB  = 29;
  localparam int unsigned BIT_GSTOP  = 28;
  localparam int unsigned BIT_TXF    = 27;
  localparam int unsigned BIT_MII    = 23;
  localparam int unsigned BIT_LCOL   = 21;
  localparam int unsigned BIT_RLIM   = 20;
  localparam int unsigned BIT_TXUN   = 19;
  localparam int unsigned BIT_TXFERR = 18;
  localparam int unsigned BIT_RXFERR = 17;

  localparam logic [REG_W-1:0] IMPL_MASK = 32'hF8BE_0000;

  typedef struct packed {
    logic hb_err;
    logic rx_bab;
    logic tx_bab;
    logic gstop;
    logic tx_frame;
    logic mii_done;
    logic late_col;
    logic retry_lim;
    logic tx_under;
    logic tx_ferr;
    logic rx_ferr;
  } ev_set_t;

  function automatic logic [REG_W-1:0] ev_to_vec(ev_set_t e);
    logic [REG_W-1:0] v;
    v             = '0;
    v[BIT_HB]     = e.hb_err;
    v[BIT_RXBAB]  = e.rx_bab;
    v[BIT_TXBAB]  = e.tx_bab;
    v[BIT_GSTOP]  = e.gstop;
    v[BIT_TXF]    = e.tx_frame;
    v[BIT_MII]    = e.mii_done;
    v[BIT_LCOL]   = e.late_col;
    v[BIT_RLIM]   = e.retry_lim;
    v[BIT_TXUN]   = e.tx_under;
    v[BIT_TXFERR] = e.tx_ferr;
    v[BIT_RXFERR] = e.rx_ferr;
    return v;
  endfunction
endpackage

// File: rtl/irq_hb_check.sv
module irq_hb_check #(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             eof_i,
  input  logic             col_i,
  output logic             err_o
);
  localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

  logic             act_q;
  logic [WIN_W-1:0] cnt_q;
  logic             last_cyc;
  logic             start;

  assign last_cyc = (cnt_q == ONE);
  assign start    = eof_i & en_i;
  assign err_o    = act_q & ~col_i & last_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= (win_i == '0) ? ONE : win_i;
    end else if (act_q) begin
      if (col_i || last_cyc) act_q <= 1'b0;
      else                   cnt_q <= cnt_q - ONE;
    end
  end

  // R6: collision seen inside window closes it without error
  a_r6_col_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && col_i && !start) |=> !act_q);
  a_r6_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q != '0));
endmodule

// File: rtl/irq_babble_det.sv
module irq_babble_det #(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_i,
  input  logic             eof_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic             over_o
);
  localparam int unsigned CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] CNT_SAT = {1'b1, {LEN_W{1'b0}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             flag_q;

  // saturates at 2^LEN_W, one past the largest limit
  assign cnt_inc = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + CNT_W'(1);
  assign over_o  = byte_i & ~flag_q & (cnt_inc > {1'b0, max_len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (eof_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (byte_i) begin
      cnt_q  <= cnt_inc;
      flag_q <= flag_q | over_o;
    end
  end

  // R7: at most one report per frame
  a_r7_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_o && !eof_i) |=> !over_o);
endmodule

// File: rtl/irq_gstop_ctl.sv
module irq_gstop_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gts_i,
  input  logic tfc_i,
  input  logic pause_rx_i,
  input  logic tx_byte_i,
  input  logic tx_eof_i,
  output logic done_o
);
  logic gts_q, tfc_q, pend_q, in_frame_q;
  logic req;

  assign req    = (gts_i & ~gts_q) | (tfc_i & ~tfc_q) | pause_rx_i;
  assign done_o = pend_q & ~in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gts_q      <= 1'b0;
      tfc_q      <= 1'b0;
      pend_q     <= 1'b0;
      in_frame_q <= 1'b0;
    end else begin
      gts_q  <= gts_i;
      tfc_q  <= tfc_i;
      pend_q <= (pend_q & ~done_o) | req;
      if (tx_eof_i)       in_frame_q <= 1'b0;
      else if (tx_byte_i) in_frame_q <= 1'b1;
    end
  end

  // R8: completion releases the pending stop
  a_r8_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !req) |=> !pend_q);
  // R8: no completion while a frame is on the wire
  a_r8_wait_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && tx_byte_i && !tx_eof_i) |=> !done_o);
endmodule

// File: rtl/mac_irq_event.sv
module mac_irq_event
  import mac_irq_pkg::*;
#(
  parameter int unsigned HB_W  = 8,
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_sel_i,
  input  logic             reg_we_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             hb_en_i,
  input  logic [HB_W-1:0]  hb_window_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             gts_req_i,
  input  logic             tfc_req_i,
  input  logic             rx_pause_i,
  input  logic             tx_byte_i,
  input  logic             tx_eof_i,
  input  logic             rx_byte_i,
  input  logic             rx_eof_i,
  input  logic             col_i,
  input  logic             tx_done_i,
  input  logic             mii_done_i,
  input  logic             late_col_i,
  input  logic             retry_lim_i,
  input  logic             tx_under_i,
  input  logic             tx_ferr_i,
  input  logic             rx_ferr_i,
  output logic             irq_o
);
  localparam int unsigned NDIR = 2; // 0 receive, 1 transmit

  logic [REG_W-1:0] ev_q, mask_q, set_vec, clr_vec;
  logic [NDIR-1:0]  dir_byte, dir_eof, dir_over;
  logic             hb_err, gs_done;
  ev_set_t          ev_set;

  irq_hb_check #(.WIN_W(HB_W)) u_hb (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (hb_en_i), .win_i (hb_window_i),
    .eof_i (tx_eof_i), .col_i (col_i), .err_o (hb_err)
  );

  assign dir_byte = {tx_byte_i, rx_byte_i};
  assign dir_eof  = {tx_eof_i,  rx_eof_i};

  for (genvar d = 0; d < NDIR; d++) begin : g_bab
    irq_babble_det #(.LEN_W(LEN_W)) u_bab (
      .clk_i (clk_i), .rst_ni (rst_ni), .byte_i (dir_byte[d]),
      .eof_i (dir_eof[d]), .max_len_i (max_len_i), .over_o (dir_over[d])
    );
  end

  irq_gstop_ctl u_gs (
    .clk_i (clk_i), .rst_ni (rst_ni), .gts_i (gts_req_i), .tfc_i (tfc_req_i),
    .pause_rx_i (rx_pause_i), .tx_byte_i (tx_byte_i), .tx_eof_i (tx_eof_i),
    .done_o (gs_done)
  );

  always_comb begin
    ev_set.hb_err    = hb_err;
    ev_set.rx_bab    = dir_over[0];
    ev_set.tx_bab    = dir_over[1];
    ev_set.gstop     = gs_done;
    ev_set.tx_frame  = tx_done_i;
    ev_set.mii_done  = mii_done_i;
    ev_set.late_col  = late_col_i;
    ev_set.retry_lim = retry_lim_i;
    ev_set.tx_under  = tx_under_i;
    ev_set.tx_ferr   = tx_ferr_i;
    ev_set.rx_ferr   = rx_ferr_i;
  end

  assign set_vec = ev_to_vec(ev_set);
  assign clr_vec = (reg_we_i && !reg_sel_i) ? reg_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      ev_q <= ((ev_q & ~clr_vec) | set_vec) & IMPL_MASK;  // set beats clear
      if (reg_we_i && reg_sel_i) mask_q <= reg_wdata_i & IMPL_MASK;
    end
  end

  assign reg_rdata_o = reg_sel_i ? mask_q : ev_q;
  assign irq_o       = |(ev_q & mask_q);

  // R2: reserved positions never hold a 1
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev_q | mask_q) & ~IMPL_MASK) == '0);
  // R4: a strobe always lands even under a clearing write
  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((ev_q & $past(set_vec)) == $past(set_vec)));
  // R3: written ones are cleared when nothing sets them
  a_r3_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_sel_i && set_vec == '0) |=> ((ev_q & $past(reg_wdata_i)) == '0));
  // R3: without an event write no bit drops
  a_r3_no_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && !reg_sel_i) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));
endmodule

// File: tb/tb_mac_irq_event.sv
module tb_mac_irq_event;
  localparam int unsigned HB_W  = 8;
  localparam int unsigned LEN_W = 11;
  localparam logic [31:0] IMPL = 32'hF8BE_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_sel = 0, reg_we = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic hb_en = 0;
  logic [HB_W-1:0] hb_win = '0;
  logic [LEN_W-1:0] max_len = '0;
  logic gts = 0, tfc = 0, rx_pause = 0;
  logic tx_byte = 0, tx_eof = 0, rx_byte = 0, rx_eof = 0, col = 0;
  logic tx_done = 0, mii_done = 0, late_col = 0, retry_lim = 0;
  logic tx_under = 0, tx_ferr = 0, rx_ferr = 0;
  logic irq;

  mac_irq_event #(.HB_W(HB_W), .LEN_W(LEN_W)) dut (
    .clk_i (clk), .rst_ni (rst_n), .reg_sel_i (reg_sel), .reg_we_i (reg_we),
    .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata), .hb_en_i (hb_en),
    .hb_window_i (hb_win), .max_len_i (max_len), .gts_req_i (gts),
    .tfc_req_i (tfc), .rx_pause_i (rx_pause), .tx_byte_i (tx_byte),
    .tx_eof_i (tx_eof), .rx_byte_i (rx_byte), .rx_eof_i (rx_eof), .col_i (col),
    .tx_done_i (tx_done), .mii_done_i (mii_done), .late_col_i (late_col),
    .retry_lim_i (retry_lim), .tx_under_i (tx_under), .tx_ferr_i (tx_ferr),
    .rx_ferr_i (rx_ferr), .irq_o (irq)
  );

  int n_cmp = 0, n_bad = 0;

  // behavioural reference state
  logic [31:0] m_ev = '0, m_mask = '0;
  bit m_hb_act = 0; int m_hb_cnt = 0;
  int m_tx_cnt = 0, m_rx_cnt = 0; bit m_tx_flag = 0, m_rx_flag = 0;
  bit m_pend = 0, m_inf = 0, m_gts_p = 0, m_tfc_p = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [31:0] s;
    s = '0;
    if (!rst_n) begin
      m_ev = '0; m_mask = '0; m_hb_act = 0; m_hb_cnt = 0;
      m_tx_cnt = 0; m_rx_cnt = 0; m_tx_flag = 0; m_rx_flag = 0;
      m_pend = 0; m_inf = 0; m_gts_p = 0; m_tfc_p = 0;
      return;
    end
    if (m_hb_act) begin
      if (col) m_hb_act = 0;
      else if (m_hb_cnt == 1) begin s[31] = 1; m_hb_act = 0; end
      else m_hb_cnt--;
    end
    if (tx_eof && hb_en) begin m_hb_act = 1; m_hb_cnt = (hb_win == 0) ? 1 : int'(hb_win); end
    if (tx_byte) begin
      m_tx_cnt++;
      if (!m_tx_flag && m_tx_cnt > int'(max_len)) begin s[29] = 1; m_tx_flag = 1; end
    end
    if (tx_eof) begin m_tx_cnt = 0; m_tx_flag = 0; end
    if (rx_byte) begin
      m_rx_cnt++;
      if (!m_rx_flag && m_rx_cnt > int'(max_len)) begin s[30] = 1; m_rx_flag = 1; end
    end
    if (rx_eof) begin m_rx_cnt = 0; m_rx_flag = 0; end
    if (m_pend && !m_inf) begin s[28] = 1; m_pend = 0; end
    if ((gts && !m_gts_p) || (tfc && !m_tfc_p) || rx_pause) m_pend = 1;
    m_gts_p = gts; m_tfc_p = tfc;
    if (tx_eof) m_inf = 0; else if (tx_byte) m_inf = 1;
    s[27] = tx_done; s[23] = mii_done; s[21] = late_col; s[20] = retry_lim;
    s[19] = tx_under; s[18] = tx_ferr; s[17] = rx_ferr;
    if (reg_we && !reg_sel) m_ev = m_ev & ~reg_wdata;
    m_ev = (m_ev | s) & IMPL;
    if (reg_we && reg_sel) m_mask = reg_wdata & IMPL;
  endtask

  // one clock: model update at the edge, compare at the falling edge, drop strobes
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(reg_rdata == (reg_sel ? m_mask : m_ev), "R3/R5 readback vs model", reg_rdata, reg_sel ? m_mask : m_ev);
    chk(irq == |(m_ev & m_mask), "R5 irq vs model", {31'b0, irq}, {31'b0, |(m_ev & m_mask)});
    reg_we = 0; tx_byte = 0; tx_eof = 0; rx_byte = 0; rx_eof = 0; rx_pause = 0;
    tx_done = 0; mii_done = 0; late_col = 0; retry_lim = 0;
    tx_under = 0; tx_ferr = 0; rx_ferr = 0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_sel = sel; reg_we = 1; reg_wdata = d; tick();
  endtask

  task automatic rd_chk(input logic sel, input logic [31:0] exp, input string tag);
    reg_sel = sel; #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic rd_bit(input int b, input bit exp, input string tag);
    reg_sel = 0; #1;
    chk(reg_rdata[b] == exp, tag, {31'b0, reg_rdata[b]}, {31'b0, exp});
  endtask

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    max_len = 11'd1500; hb_win = 8'd5;
    repeat (3) tick();
    rd_chk(0, 32'h0, "R1 event at reset");
    rd_chk(1, 32'h0, "R1 mask at reset");
    chk(irq == 0, "R1 irq at reset", {31'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1;
    tick();

    // R2 layout: all ones into mask reads back only implemented bits
    wr(1, 32'hFFFF_FFFF);
    rd_chk(1, IMPL, "R2 mask implemented bits");
    wr(1, 32'h0);

    // R10 strobes map to their bits
    tx_done = 1; tick(); rd_bit(27, 1, "R10 tx_done bit 27");
    mii_done = 1; tick(); rd_bit(23, 1, "R10 mii_done bit 23");
    late_col = 1; retry_lim = 1; tick();
    tx_under = 1; tx_ferr = 1; rx_ferr = 1; tick();
    rd_chk(0, 32'h08BE_0000, "R10 all simple strobes");
    chk(irq == 0, "R5 masked events latch without irq", {31'b0, irq}, 32'h0);

    // R3 write zero keeps, write one clears, reserved writes ignored
    wr(0, 32'h0000_0000);
    rd_chk(0, 32'h08BE_0000, "R3 zero write keeps");
    wr(0, 32'h0080_0000);
    rd_chk(0, 32'h083E_0000, "R3 one clears bit 23");
    wr(0, 32'h0741_FFFF);
    rd_chk(0, 32'h083E_0000, "R2 reserved write no effect");

    // R4 set and clear together
    reg_sel = 0; reg_we = 1; reg_wdata = 32'h0800_0000; tx_done = 1; tick();
    rd_bit(27, 1, "R4 set wins over clear");

    // R5 mask gating
    wr(1, 32'h0010_0000);
    chk(irq == 1, "R5 irq on masked-in bit", {31'b0, irq}, 32'h1);
    wr(0, 32'h0010_0000);
    chk(irq == 0, "R5 irq drops after clear", {31'b0, irq}, 32'h0);
    wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'h0, "R3 clear all");

    // R6 heartbeat, no collision: bit 31 after window of 5
    hb_en = 1;
    tx_byte = 1; tick(); tx_byte = 1; tick(); tx_byte = 1; tx_eof = 1; tick();
    repeat (4) tick();
    rd_bit(31, 0, "R6 no error inside window");
    tick();
    rd_bit(31, 1, "R6 error after window");
    wr(0, 32'h8000_0000);
    // R6 collision inside window
    tx_byte = 1; tx_eof = 1; tick();
    tick(); col = 1; tick(); col = 0;
    repeat (6) tick();
    rd_bit(31, 0, "R6 collision suppresses error");
    // R6 window of zero acts as one
    hb_win = 0; tx_byte = 1; tx_eof = 1; tick(); tick();
    rd_bit(31, 1, "R6 zero window acts as one");
    wr(0, 32'h8000_0000); hb_en = 0; hb_win = 8'd5;

    // R7 babble transmit: max 10, byte 11 triggers
    max_len = 11'd10;
    repeat (10) begin tx_byte = 1; tick(); end
    rd_bit(29, 0, "R7 tx at limit no babble");
    tx_byte = 1; tick();
    rd_bit(29, 1, "R7 tx over limit babble");
    wr(0, 32'h2000_0000);
    repeat (3) begin tx_byte = 1; tick(); end
    rd_bit(29, 0, "R7 only once per frame");
    tx_byte = 1; tx_eof = 1; tick();
    // R7 receive: exactly max bytes no babble, next frame over
    repeat (9) begin rx_byte = 1; tick(); end
    rx_byte = 1; rx_eof = 1; tick();
    rd_bit(30, 0, "R7 rx frame at limit");
    repeat (11) begin rx_byte = 1; tick(); end
    rd_bit(30, 1, "R7 rx over limit");
    rx_byte = 1; rx_eof = 1; tick();
    wr(0, 32'hFFFF_FFFF);
    max_len = 11'd1500;

    // R8 stop during frame waits for eof
    tx_byte = 1; tick();
    gts = 1; tx_byte = 1; tick();
    repeat (3) begin tx_byte = 1; tick(); end
    rd_bit(28, 0, "R8 no stop mid frame");
    tx_byte = 1; tx_eof = 1; tick();
    rd_bit(28, 0, "R8 not at eof edge");
    tick();
    rd_bit(28, 1, "R8 stop two cycles after eof");
    wr(0, 32'h1000_0000);
    // R9 idle request via received pause
    rx_pause = 1; tick();
    rd_bit(28, 0, "R9 not yet");
    tick();
    rd_bit(28, 1, "R9 idle completes");
    wr(0, 32'h1000_0000);
    // R9 idle request via pause request level rise
    tfc = 1; tick(); tick();
    rd_bit(28, 1, "R9 pause request rise");
    wr(0, 32'h1000_0000);
    repeat (3) tick();
    rd_bit(28, 0, "R8 held level no repeat");
    gts = 0; tfc = 0;

    // mixed traffic against the model
    max_len = 11'd6; hb_win = 8'd3; hb_en = 1;
    for (int i = 0; i < 2000; i++) begin
      tx_byte = ($urandom_range(0, 3) != 0);
      tx_eof = tx_byte && ($urandom_range(0, 9) == 0);
      rx_byte = ($urandom_range(0, 2) != 0);
      rx_eof = rx_byte && ($urandom_range(0, 9) == 0);
      col = ($urandom_range(0, 7) == 0);
      rx_pause = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 30) == 0) gts = ~gts;
      if ($urandom_range(0, 30) == 0) tfc = ~tfc;
      tx_done = ($urandom_range(0, 15) == 0);
      mii_done = ($urandom_range(0, 15) == 0);
      late_col = ($urandom_range(0, 15) == 0);
      retry_lim = ($urandom_range(0, 15) == 0);
      tx_under = ($urandom_range(0, 15) == 0);
      tx_ferr = ($urandom_range(0, 15) == 0);
      rx_ferr = ($urandom_range(0, 15) == 0);
      reg_sel = $urandom_range(0, 1);
      reg_we = ($urandom_range(0, 5) == 0);
      reg_wdata = $urandom;
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule